// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two operands of a parameterised width (32 bits by default) and returns a product twice that width. It takes one multiplier bit per clock cycle. A single register of twice the operand width holds the product. The multiplier operand is loaded into the lower half of that register. Each cycle, the bit at the bottom of the register decides whether the stored multiplicand is added into the upper half. The whole register, with the adder's carry on top, then moves right by one position. This needs only one adder of operand width.

A one-cycle start request launches an operation, provided the block is idle. The block reports busy while it iterates. When it finishes, it raises done for one cycle. The product stays readable until the next accepted start. A per-operation signed select makes the block treat both operands as two's complement: it turns them into magnitudes before the loop and negates the result when the operand signs differ.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, busy_o, done_o and product_o are all zero.
- R2: A start_i sampled high at a clock edge while busy_o is low is accepted, and busy_o reads 1 after that edge.
- R3: With signed_i low at the accepted start, the product is the unsigned product of a_i and b_i. For example, 2 times 11 gives 22.
- R4: busy_o stays high for exactly WIDTH clock cycles after the accepting edge. done_o rises at the edge that clears busy_o.
- R5: done_o is high for exactly one cycle, and busy_o is low whenever done_o is high.
- R6: A start_i raised while busy_o is high is ignored. The running result and its completion cycle are unchanged.
- R7: With signed_i high at the accepted start, a_i and b_i are read as two's complement. The product is their signed product in 2*WIDTH bits, and this includes the most negative operand value.
- R8: While the block is idle and no start is accepted, product_o holds its value.
- R9: The carry out of the adder is kept. An all-ones operand times an all-ones operand gives 2^(2W) - 2^(W+1) + 1 (0xFFFFFFFE00000001 for W=32).
- R10: Operands and signed_i are captured only at the accepted start. Changing them during busy_o has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an operation |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| a_i | input | WIDTH | Multiplicand operand |
| b_i | input | WIDTH | Multiplier operand |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2*WIDTH | Result, valid from done_o until the next accepted start |

## Verification
On every cycle, the assertions check the following:
- an accepted start raises busy;
- done is a single-cycle pulse that never overlaps busy;
- every operation spends exactly WIDTH cycles busy, counted independently in the checker;
- the product stays stable while idle.

The values of the products can only be shown by the bench's scenarios. These include the unsigned and signed arithmetic, the carry case with all-ones operands, and the most negative signed operand. The bench scenarios also show that a start raised mid-run, or operands changed mid-run, leave the result untouched.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic             signed_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] a_mag_o,
  output logic [WIDTH-1:0] b_mag_o,
  output logic             neg_o
);
  logic a_neg, b_neg;

  assign a_neg   = signed_i & a_i[WIDTH-1];
  assign b_neg   = signed_i & b_i[WIDTH-1];
  // most negative value maps onto itself, which is the correct unsigned magnitude
  assign a_mag_o = a_neg ? (~a_i + WIDTH'(1)) : a_i;
  assign b_mag_o = b_neg ? (~b_i + WIDTH'(1)) : b_i;
  assign neg_o   = a_neg ^ b_neg;
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  mul_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign load_o = start_i & (state_q == ST_IDLE);
  assign step_o = (state_q == ST_RUN);
  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
          cnt_q <= cnt_q + CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int WIDTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] prod_o
);
  logic [WIDTH-1:0]   mcand_q;
  logic [2*WIDTH-1:0] prod_q;
  logic [WIDTH:0]     sum;
  logic [WIDTH:0]     upper_nxt;

  assign sum       = {1'b0, prod_q[2*WIDTH-1:WIDTH]} + {1'b0, mcand_q};
  assign upper_nxt = prod_q[0] ? sum : {1'b0, prod_q[2*WIDTH-1:WIDTH]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{WIDTH{1'b0}}, mplier_i};
    end else if (step_i) begin
      // carry becomes the new top bit as the register shifts right
      prod_q  <= {upper_nxt, prod_q[WIDTH-1:1]};
    end
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/mul_result_fix.sv
module mul_result_fix #(
  parameter int WIDTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               neg_i,
  input  logic [2*WIDTH-1:0] raw_i,
  output logic [2*WIDTH-1:0] result_o
);
  logic neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     neg_q <= 1'b0;
    else if (load_i) neg_q <= neg_i;
  end

  assign result_o = neg_q ? (~raw_i + (2*WIDTH)'(1)) : raw_i;
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int WIDTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               signed_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic               load, step, neg;
  logic [WIDTH-1:0]   a_mag, b_mag;
  logic [2*WIDTH-1:0] raw;

  mul_operand_prep #(.WIDTH(WIDTH)) i_prep (
    .signed_i(signed_i), .a_i(a_i), .b_i(b_i),
    .a_mag_o(a_mag), .b_mag_o(b_mag), .neg_o(neg)
  );

  mul_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .load_o(load), .step_o(step), .busy_o(busy_o), .done_o(done_o)
  );

  mul_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step),
    .mcand_i(a_mag), .mplier_i(b_mag), .prod_o(raw)
  );

  mul_result_fix #(.WIDTH(WIDTH)) i_fix (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .neg_i(neg),
    .raw_i(raw), .result_o(product_o)
  );
endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o
);
  localparam int CW = $clog2(WIDTH + 1) + 1;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt <= '0;
    else if (!busy_o) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + CW'(1);
  end

  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R2
  AST_ITER_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_cnt == CW'(WIDTH)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(product_o)); // R8
endmodule

bind shift_add_mul shift_add_mul_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
);

// File: tb/test_shift_add_mul.sv
`timescale 1ns/1ps
module test_shift_add_mul;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           sgn = 1'b0;
  logic [W-1:0]   a = '0, b = '0;
  logic           busy, done;
  logic [2*W-1:0] prod;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  shift_add_mul #(.WIDTH(W)) i_shift_add_mul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .a_i(a), .b_i(b), .busy_o(busy), .done_o(done), .product_o(prod)
  );

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] x, logic [W-1:0] y, logic s);
    logic [2*W-1:0] xe, ye;
    xe = s ? {{W{x[W-1]}}, x} : {{W{1'b0}}, x};
    ye = s ? {{W{y[W-1]}}, y} : {{W{1'b0}}, y};
    return xe * ye;
  endfunction

  task automatic check(bit ok, string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // disturb: 0 none, 1 restart mid-run, 2 change operands mid-run
  task automatic run_op(logic [W-1:0] x, logic [W-1:0] y, logic s, int disturb, string req);
    int cyc;
    logic [2*W-1:0] exp, held;
    exp = ref_mul(x, y, s);
    @(negedge clk);
    a = x; b = y; sgn = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2", {63'b0, busy}, 64'd1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 100) begin
      if (cyc == 5 && disturb == 1) begin
        a = ~x; b = y ^ 32'h5a5a_5a5a; sgn = ~s; start = 1'b1;
      end else if (cyc == 5 && disturb == 2) begin
        a = x + 32'd3; b = ~y; sgn = ~s;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == W, "R4", 64'(cyc), 64'(W));
    check(busy === 1'b0, "R5", {63'b0, busy}, 64'd0);
    check(prod === exp, req, prod, exp);
    held = prod;
    @(negedge clk);
    check(done === 1'b0, "R5", {63'b0, done}, 64'd0);
    @(negedge clk);
    check(prod === held, "R8", prod, held);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", {62'b0, busy, done}, 64'd0);
    check(prod === '0, "R1", prod, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(32'd2, 32'd11, 1'b0, 0, "R3");
    run_op(32'd0, 32'hffff_ffff, 1'b0, 0, "R3");
    run_op(32'd1, 32'hdead_beef, 1'b0, 0, "R3");
    run_op(32'hffff_ffff, 32'hffff_ffff, 1'b0, 0, "R9");
    run_op(32'hffff_ffff, 32'd1, 1'b0, 0, "R9");
    run_op(32'd1234, 32'd5678, 1'b0, 1, "R6");
    run_op(32'h8000_0001, 32'h7fff_0003, 1'b0, 2, "R10");
    run_op(32'hffff_fffe, 32'd3, 1'b1, 0, "R7");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 0, "R7");
    run_op(32'h8000_0000, 32'd1, 1'b1, 0, "R7");
    run_op(32'hffff_ffff, 32'hffff_ffff, 1'b1, 0, "R7");
    run_op(32'h7fff_ffff, 32'h8000_0000, 1'b1, 1, "R6");
    run_op(32'hfedc_ba98, 32'h0123_4567, 1'b1, 2, "R10");

    for (int i = 0; i < 40; i++) begin
      run_op($urandom, $urandom, 1'($urandom), 0, (i % 2) ? "R3" : "R7");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule